// File: doc/BRIEF.md
# Asynchronous Abort Mask and Pending Unit

This block decides when an asynchronous (imprecise external) abort may enter the processor's exception path. It keeps one mask bit and one pending latch. An abort request that arrives while the mask is set is latched rather than dropped. The latched abort is delivered as soon as software clears the mask. Software can read the pending state at any time without unmasking and without taking the exception.

The mask bit sets itself on reset, on entry to an abort, IRQ or FIQ exception, and when the core acknowledges a delivered abort. Software may write the mask through a one-bit write port, but an automatic set in the same cycle overrides a software clear. Software has no way to discard a pending abort. Only the core's acknowledge of the take request clears the latch.

All three outputs come straight from flops. They change on the clock edge that samples the causing input.

Top module: `async_abort_gate`

## Requirements
- R1: The take-abort output `take_o` is never high while `mask_o` is high. An abort that arrives while masked is not delivered.
- R2: Whenever `pend_o` is 1 and `mask_o` is 0, `take_o` is 1. When the mask clears with an abort pending, `take_o` rises on the same edge that clears `mask_o`.
- R3: An abort exception entry (`ent_abt_i`=1) or an acknowledge (`take_ack_i`=1) makes `mask_o` 1 after the next edge.
- R4: An IRQ entry (`ent_irq_i`=1) or an FIQ entry (`ent_fiq_i`=1) makes `mask_o` 1 after the next edge. If `take_o` was high, it drops while `pend_o` stays 1.
- R5: While `rst` is sampled high, the next edge leaves `mask_o`=1, `pend_o`=0 and `take_o`=0.
- R6: `pend_o` reports a latched abort while masked. It keeps reporting it across any number of cycles, mask writes of 1, and IRQ/FIQ entries.
- R7: `pend_o` falls only on the edge after `take_ack_i` was 1. No software write clears it.
- R8: Several requests while pending merge into one pending abort. After one acknowledge with no new request, `pend_o` is 0.
- R9: An abort request sampled in the first cycle after `rst` deasserts is latched (`pend_o`=1) and not delivered (`take_o`=0), because the mask is already set.
- R10: If an exception entry and a software write of `mask_wr_val_i`=0 happen in the same cycle, the mask ends up 1.
- R11: An abort request in the same cycle as a mask write of 0 (no entry, no acknowledge) gives `take_o`=1 after that one edge, with no extra masked cycle.
- R12: With no entry and no acknowledge, a write (`mask_wr_en_i`=1) loads `mask_wr_val_i` into `mask_o` after the next edge. With no write and no automatic set, `mask_o` holds.
- R13: `take_o` holds high until acknowledged, unless an entry or a mask write of 1 sets the mask. A new request in the acknowledge cycle leaves `pend_o`=1 with `mask_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abt_req_i | input | 1 | Asynchronous abort request, one per asserted cycle |
| ent_abt_i | input | 1 | Abort exception entry taken this cycle |
| ent_irq_i | input | 1 | IRQ exception entry taken this cycle |
| ent_fiq_i | input | 1 | FIQ exception entry taken this cycle |
| mask_wr_en_i | input | 1 | Software write strobe for the mask bit |
| mask_wr_val_i | input | 1 | Value written to the mask bit |
| take_ack_i | input | 1 | Core acknowledges the abort was taken |
| take_o | output | 1 | Request to take the abort exception |
| mask_o | output | 1 | Current mask bit |
| pend_o | output | 1 | Abort pending status |

## Verification
The assertions assume the core raises `take_ack_i` only in a cycle where `take_o` is high. Under that assumption an acknowledge always retires a delivered abort, and the rule that the latch clears only on acknowledge is meaningful. The directed bench keeps to this by acknowledging only after it has observed `take_o` high at its sampling point. Abort requests, entries and mask writes are otherwise driven freely, including in the same cycle as each other, since the block defines a priority for every such overlap.

// File: rtl/abt_pkg.sv
package abt_pkg;
  // Source of the next mask value, in priority order (auto set wins).
  typedef enum logic [1:0] {
    MSK_HOLD = 2'd0,
    MSK_SW   = 2'd1,
    MSK_AUTO = 2'd2
  } msk_src_e;

  function automatic msk_src_e pick_mask_src(input logic auto_set,
                                             input logic wr_en);
    if (auto_set)   return MSK_AUTO;
    else if (wr_en) return MSK_SW;
    else            return MSK_HOLD;
  endfunction
endpackage

// File: rtl/abt_mask_reg.sv
module abt_mask_reg
  import abt_pkg::*;
#(
  parameter logic MASK_RST = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic auto_set_i,
  input  logic wr_en_i,
  input  logic wr_val_i,
  output logic mask_o,
  output logic mask_nxt_o
);
  msk_src_e src;

  always_comb begin
    src = pick_mask_src(auto_set_i, wr_en_i);
    unique case (src)
      MSK_AUTO: mask_nxt_o = 1'b1;
      MSK_SW:   mask_nxt_o = wr_val_i;
      default:  mask_nxt_o = mask_o;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mask_o <= MASK_RST;
    else     mask_o <= mask_nxt_o;
  end

  // Automatic set dominates any software value (R10)
  assert_auto_dominates_R10: assert property (@(posedge clk) disable iff (rst)
    (auto_set_i && wr_en_i && !wr_val_i) |=> mask_o);

  // Plain software write lands, otherwise the bit holds (R12)
  assert_sw_write_R12: assert property (@(posedge clk) disable iff (rst)
    (!auto_set_i && wr_en_i) |=> (mask_o == $past(wr_val_i)));
  assert_mask_holds_R12: assert property (@(posedge clk) disable iff (rst)
    (!auto_set_i && !wr_en_i) |=> $stable(mask_o));
endmodule

// File: rtl/abt_pend_latch.sv
module abt_pend_latch (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic ack_i,
  output logic pend_o,
  output logic pend_nxt_o
);
  // A request always sets; acknowledge is the only clear.
  always_comb pend_nxt_o = req_i | (pend_o & ~ack_i);

  always_ff @(posedge clk) begin
    if (rst) pend_o <= 1'b0;
    else     pend_o <= pend_nxt_o;
  end

  // Only the acknowledge clears the latch (R7)
  assert_clear_only_on_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(pend_o)) |-> $past(ack_i));

  // Pending survives while unacknowledged (R6)
  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !ack_i) |=> pend_o);

  // Merged requests retire with a single acknowledge (R8)
  assert_single_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !req_i) |=> !pend_o);
endmodule

// File: rtl/abt_deliver.sv
module abt_deliver (
  input  logic clk,
  input  logic rst,
  input  logic pend_nxt_i,
  input  logic mask_nxt_i,
  output logic take_o
);
  // Registered from the next-state values so take_o lines up with
  // pend_o/mask_o on the same edge (no extra masked cycle).
  always_ff @(posedge clk) begin
    if (rst) take_o <= 1'b0;
    else     take_o <= pend_nxt_i & ~mask_nxt_i;
  end
endmodule

// File: rtl/async_abort_gate.sv
module async_abort_gate (
  input  logic clk,
  input  logic rst,
  input  logic abt_req_i,
  input  logic ent_abt_i,
  input  logic ent_irq_i,
  input  logic ent_fiq_i,
  input  logic mask_wr_en_i,
  input  logic mask_wr_val_i,
  input  logic take_ack_i,
  output logic take_o,
  output logic mask_o,
  output logic pend_o
);
  logic auto_set;
  logic mask_nxt;
  logic pend_nxt;

  // Acknowledge counts as abort entry for masking purposes.
  assign auto_set = ent_abt_i | ent_irq_i | ent_fiq_i | take_ack_i;

  abt_mask_reg #(.MASK_RST(1'b1)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .auto_set_i (auto_set),
    .wr_en_i    (mask_wr_en_i),
    .wr_val_i   (mask_wr_val_i),
    .mask_o     (mask_o),
    .mask_nxt_o (mask_nxt)
  );

  abt_pend_latch u_pend (
    .clk        (clk),
    .rst        (rst),
    .req_i      (abt_req_i),
    .ack_i      (take_ack_i),
    .pend_o     (pend_o),
    .pend_nxt_o (pend_nxt)
  );

  abt_deliver u_deliver (
    .clk        (clk),
    .rst        (rst),
    .pend_nxt_i (pend_nxt),
    .mask_nxt_i (mask_nxt),
    .take_o     (take_o)
  );

  // Never deliver while masked (R1)
  assert_no_take_masked_R1: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !mask_o);

  // Pending and unmasked means delivered (R2)
  assert_pending_delivered_R2: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !mask_o) |-> take_o);
  assert_take_has_pending_R2: assert property (@(posedge clk) disable iff (rst)
    take_o |-> pend_o);

  // Abort entry or acknowledge masks (R3)
  assert_abt_entry_masks_R3: assert property (@(posedge clk) disable iff (rst)
    (ent_abt_i || take_ack_i) |=> mask_o);

  // IRQ / FIQ entry masks (R4)
  assert_irq_fiq_masks_R4: assert property (@(posedge clk) disable iff (rst)
    (ent_irq_i || ent_fiq_i) |=> (mask_o && !take_o));

  // Reset state (R5)
  assert_reset_state_R5: assert property (@(posedge clk)
    $past(rst) |-> (mask_o && !pend_o && !take_o));

  // Same-cycle request and unmask is delivered at once (R11)
  assert_same_cycle_R11: assert property (@(posedge clk) disable iff (rst)
    (abt_req_i && mask_wr_en_i && !mask_wr_val_i && !auto_set) |=> take_o);

  // Take holds until acknowledged or masked again (R13)
  assert_take_holds_R13: assert property (@(posedge clk) disable iff (rst)
    (take_o && !auto_set && !(mask_wr_en_i && mask_wr_val_i)) |=> take_o);
  assert_req_on_ack_R13: assert property (@(posedge clk) disable iff (rst)
    (take_ack_i && abt_req_i) |=> (pend_o && mask_o && !take_o));

  // Input assumption: acknowledge only while a take is offered
  assert_ack_legal_R7: assert property (@(posedge clk) disable iff (rst)
    take_ack_i |-> take_o);
endmodule

// File: tb/async_abort_gate_tb.sv
module async_abort_gate_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic abt_req_i = 1'b0, ent_abt_i = 1'b0, ent_irq_i = 1'b0, ent_fiq_i = 1'b0;
  logic mask_wr_en_i = 1'b0, mask_wr_val_i = 1'b0, take_ack_i = 1'b0;
  logic take_o, mask_o, pend_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  async_abort_gate u_dut (
    .clk(clk), .rst(rst), .abt_req_i(abt_req_i), .ent_abt_i(ent_abt_i),
    .ent_irq_i(ent_irq_i), .ent_fiq_i(ent_fiq_i), .mask_wr_en_i(mask_wr_en_i),
    .mask_wr_val_i(mask_wr_val_i), .take_ack_i(take_ack_i),
    .take_o(take_o), .mask_o(mask_o), .pend_o(pend_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic chk3(input string tag, input logic t, input logic m, input logic p);
    chk({tag, " take"}, take_o, t);
    chk({tag, " mask"}, mask_o, m);
    chk({tag, " pend"}, pend_o, p);
  endtask

  // Advance one edge; inputs were driven 1 ns after the previous edge.
  task automatic step();
    @(posedge clk);
    #1;
    abt_req_i = 0; ent_abt_i = 0; ent_irq_i = 0; ent_fiq_i = 0;
    mask_wr_en_i = 0; mask_wr_val_i = 0; take_ack_i = 0;
  endtask

  task automatic wr_mask(input logic v);
    mask_wr_en_i = 1; mask_wr_val_i = v; step();
  endtask

  task automatic ack_take();
    take_ack_i = 1; step();
  endtask

  task automatic t_reset();
    rst = 1; step(); step();
    chk3("R5 reset", 0, 1, 0);
    rst = 0; abt_req_i = 1; step();
    chk3("R9 req at reset release", 0, 1, 1);
    wr_mask(0);
    chk3("R2 unmask delivers", 1, 0, 1);
    ack_take();
    chk3("R3 ack masks and clears", 0, 1, 0);
  endtask

  task automatic t_masked_hold();
    abt_req_i = 1; step();
    chk3("R1 masked not delivered", 0, 1, 1);
    for (int i = 0; i < 3; i++) step();
    chk3("R6 pending held idle", 0, 1, 1);
    wr_mask(1);
    chk("R7 write 1 keeps pend", pend_o, 1);
    ent_irq_i = 1; step();
    chk("R6 irq keeps pend", pend_o, 1);
    wr_mask(0);
    chk3("R2 delivered on unmask", 1, 0, 1);
    step(); step();
    chk("R13 take holds without ack", take_o, 1);
    ent_fiq_i = 1; step();
    chk3("R4 fiq withdraws take", 0, 1, 1);
    wr_mask(0);
    chk("R2 redelivered", take_o, 1);
    ack_take();
    chk3("R7 ack clears pend", 0, 1, 0);
  endtask

  task automatic t_merge();
    for (int i = 0; i < 3; i++) begin abt_req_i = 1; step(); end
    chk("R8 merged pending", pend_o, 1);
    wr_mask(0);
    chk("R8 one take", take_o, 1);
    ack_take();
    chk3("R8 single ack retires all", 0, 1, 0);
  endtask

  task automatic t_entries();
    wr_mask(0);
    chk("R12 write 0", mask_o, 0);
    step();
    chk("R12 mask holds", mask_o, 0);
    ent_irq_i = 1; step();
    chk("R4 irq sets mask", mask_o, 1);
    wr_mask(0);
    ent_fiq_i = 1; step();
    chk("R4 fiq sets mask", mask_o, 1);
    wr_mask(0);
    ent_abt_i = 1; step();
    chk("R3 abort entry sets mask", mask_o, 1);
    wr_mask(0);
    ent_irq_i = 1; mask_wr_en_i = 1; mask_wr_val_i = 0; step();
    chk("R10 entry beats sw clear", mask_o, 1);
    wr_mask(0);
    wr_mask(1);
    chk("R12 write 1", mask_o, 1);
  endtask

  task automatic t_same_cycle();
    abt_req_i = 1; mask_wr_en_i = 1; mask_wr_val_i = 0; step();
    chk3("R11 req with unmask", 1, 0, 1);
    take_ack_i = 1; abt_req_i = 1; step();
    chk3("R13 req during ack", 0, 1, 1);
    wr_mask(0);
    chk("R2 second delivery", take_o, 1);
    ack_take();
    chk3("R3 final ack", 0, 1, 0);
    wr_mask(0);
    abt_req_i = 1; step();
    chk3("R2 unmasked req delivered", 1, 0, 1);
    ack_take();
    chk3("R3 ack after unmasked req", 0, 1, 0);
  endtask

  initial begin
    #1;
    t_reset();
    t_masked_hold();
    t_merge();
    t_entries();
    t_same_cycle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule